// File: doc/BRIEF.md
# Dual-Channel Bi-Level Boost Timer

This block produces the boost enables for the two windings of a unipolar stepper drive. Each winding has a counter-based one-shot. When that winding's phase changes, its one-shot raises the winding's boost enable for a programmed number of clock cycles. The boost enable switches in the high-voltage second supply, so winding current rises quickly at the start of a step. When the count runs out, the enable drops and the winding runs from its normal supply.

Both channels read one shared 16-bit duration value. A common inhibit input forces both enables low and stops any pulse in progress. Each phase-change input is a single-cycle pulse from the phase logic. The duration value is sampled at the moment a trigger is accepted.

Top module: `boost_pulse_pair`

## Requirements
- R1: While reset is asserted, both boost outputs are 0, whatever the other inputs do.
- R2: A trigger on channel k (bit k of `phase_chg_i`, bit 0 = winding A, bit 1 = winding B), sampled at a clock edge with inhibit low and duration D > 0, holds `boost_o[k]` at 1 for exactly D cycles, starting in the cycle after that edge.
- R3: A trigger on one channel does not change the other channel's output.
- R4: A trigger that arrives while a channel's pulse is active restarts the full duration from that edge.
- R5: A trigger accepted while the duration value is 0 leaves that channel's output at 0, and also ends any pulse in progress.
- R6: While `inhibit_i` is 1, both boost outputs are 0 in the same cycle.
- R7: Triggers sampled while `inhibit_i` is 1 are ignored. No pulse appears after inhibit is released.
- R8: The duration is captured when the trigger is accepted. Changing `dur_i` during a pulse does not change that pulse's length.
- R9: A pulse cut short by inhibit does not resume when inhibit falls.
- R10: Reset is asserted asynchronously and released synchronously. The first trigger that can be accepted is the one sampled two clock edges after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_chg_i | input | 2 | Single-cycle phase-change triggers; bit 0 = winding A, bit 1 = winding B |
| dur_i | input | 16 | Shared boost duration in clock cycles; 0 disables boosting |
| inhibit_i | input | 1 | Forces both boost outputs off and discards pending pulses |
| boost_o | output | 2 | Boost enables; bit 0 = winding A, bit 1 = winding B |

## Verification
The bench measures pulse widths at the cycle level, so a counter that is off by one (D-1 or D+1 cycles high) shows up at once. A retrigger near the end of a pulse catches a design that extends the pulse instead of reloading it, or that ignores triggers while busy. Inhibit is applied in the middle of a pulse and released afterwards: a design that only masks the output, without clearing the count, would show the tail of the pulse after release. Changing the duration mid-pulse and triggering with a zero duration expose a design that reads `dur_i` continuously instead of capturing it at the trigger.

// File: rtl/boost_pkg.sv
package boost_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic [0:0] {
    CH_A = 1'b0,
    CH_B = 1'b1
  } boost_ch_e;
endpackage

// File: rtl/boost_rst_sync.sv
module boost_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/boost_trig_gate.sv
module boost_trig_gate #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] phase_chg_i,
  input  logic         inhibit_i,
  output logic [N-1:0] load_o,
  output logic         clear_o
);
  always_comb begin
    load_o  = phase_chg_i & ~{N{inhibit_i}};
    clear_o = inhibit_i;
  end
endmodule

// File: rtl/boost_oneshot.sv
module boost_oneshot #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] dur_i,
  output logic         active_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clear_i | load_i | busy;
    if (clear_i) begin
      cnt_d = '0;
    end else if (load_i) begin
      cnt_d = dur_i;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = busy;
endmodule

// File: rtl/boost_pulse_pair.sv
module boost_pulse_pair #(
  parameter int unsigned DUR_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [boost_pkg::NUM_CH-1:0]       phase_chg_i,
  input  logic [DUR_W-1:0]                   dur_i,
  input  logic                               inhibit_i,
  output logic [boost_pkg::NUM_CH-1:0]       boost_o
);
  localparam int unsigned NCH = boost_pkg::NUM_CH;

  logic           rst_sync_n;
  logic [NCH-1:0] load;
  logic           clear;
  logic [NCH-1:0] active;

  boost_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  boost_trig_gate #(.N(NCH)) u_gate (
    .phase_chg_i (phase_chg_i),
    .inhibit_i   (inhibit_i),
    .load_o      (load),
    .clear_o     (clear)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    boost_oneshot #(.W(DUR_W)) u_shot (
      .clk_i    (clk_i),
      .rst_ni   (rst_sync_n),
      .load_i   (load[g]),
      .clear_i  (clear),
      .dur_i    (dur_i),
      .active_o (active[g])
    );
  end

  assign boost_o = active & ~{NCH{inhibit_i}};
endmodule

// File: rtl/boost_pulse_pair_chk.sv
module boost_pulse_pair_chk #(
  parameter int unsigned DUR_W = 16,
  parameter int unsigned NCH   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_sync_ni,
  input logic [NCH-1:0]   phase_chg_i,
  input logic [DUR_W-1:0] dur_i,
  input logic             inhibit_i,
  input logic [NCH-1:0]   boost_o
);
  // R1: no boost while the reset pin is low
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (boost_o == '0);
    end
  end

  // R6
  a_r6_inhibit_off: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    inhibit_i |-> (boost_o == '0));

  // R7, R9
  a_r7_no_pulse_after_inhibit: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    inhibit_i |=> (boost_o == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R2, R4
    a_r2_trigger_starts: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
      (phase_chg_i[c] && !inhibit_i && dur_i != '0) |=> (boost_o[c] || inhibit_i));
    // R5
    a_r5_zero_duration: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
      (phase_chg_i[c] && !inhibit_i && dur_i == '0) |=> !boost_o[c]);
    // R3: a rising output needs its own trigger
    a_r3_own_trigger: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
      $rose(boost_o[c]) |-> ($past(phase_chg_i[c]) || $past(inhibit_i)));
  end
endmodule

bind boost_pulse_pair boost_pulse_pair_chk #(.DUR_W(DUR_W), .NCH(boost_pkg::NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_sync_ni (rst_sync_n),
  .phase_chg_i (phase_chg_i),
  .dur_i       (dur_i),
  .inhibit_i   (inhibit_i),
  .boost_o     (boost_o)
);

// File: tb/boost_pulse_pair_tb_top.sv
module boost_pulse_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  chg;
  logic [15:0] dur;
  logic        inh;
  logic [1:0]  boost;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  int    rem[2];
  int    rel_cnt;

  always #5 clk = ~clk;

  boost_pulse_pair dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phase_chg_i (chg),
    .dur_i       (dur),
    .inhibit_i   (inh),
    .boost_o     (boost)
  );

  // Reference model: remaining pulse cycles per channel, R10 release after two edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem[0] = 0; rem[1] = 0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (inh) rem[k] = 0;
        else if (chg[k]) rem[k] = int'(dur);
        else if (rem[k] > 0) rem[k]--;
      end
    end
  end

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // compare now (inputs already set), then advance one cycle
  task automatic cyc();
    logic [1:0] e;
    #1;
    e[0] = (rem[0] != 0) && !inh && rst_n;
    e[1] = (rem[1] != 0) && !inh && rst_n;
    check(tag, boost, e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic trig(logic [1:0] m);
    chg = m; cyc(); chg = 2'b00;
  endtask

  // counts consecutive high cycles on channel ch
  task automatic width(int ch, output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      #1;
      if (!boost[ch]) break;
      n++;
      cyc();
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; chg = 2'b11; dur = 16'd4; inh = 1'b0;
    @(negedge clk);
    tag = "R1";
    run(4);
    chg = 2'b00;
    rst_n = 1'b1;
    // R10: triggers before release completes are ignored
    tag = "R10";
    trig(2'b01);
    run(4);
    check("R10", boost, 2'b00);

    // R2 + R3: pulse on A, B quiet
    tag = "R2"; dur = 16'd5;
    trig(2'b01);
    width(0, w);
    checks++; if (w != 5) begin fails++; $display("FAIL R2 actual=%0d expected=5", w); end
    run(3);
    tag = "R3"; dur = 16'd3;
    trig(2'b10);
    #1 check("R3", boost, 2'b10);
    width(1, w);
    checks++; if (w != 3) begin fails++; $display("FAIL R3 actual=%0d expected=3", w); end
    run(2);

    // R4: retrigger after 3 high cycles -> 3 + 6
    tag = "R4"; dur = 16'd6;
    trig(2'b01);
    run(2);
    trig(2'b01);
    width(0, w);
    checks++; if (w != 6) begin fails++; $display("FAIL R4 actual=%0d expected=6", w); end
    run(2);

    // R8: change duration mid-pulse
    tag = "R8"; dur = 16'd7;
    trig(2'b10);
    dur = 16'd2;
    width(1, w);
    checks++; if (w != 7) begin fails++; $display("FAIL R8 actual=%0d expected=7", w); end
    run(2);

    // R5: zero duration, also cancels a running pulse
    tag = "R5"; dur = 16'd0;
    trig(2'b11);
    run(3);
    check("R5", boost, 2'b00);
    dur = 16'd9;
    trig(2'b01);
    run(2);
    dur = 16'd0;
    trig(2'b01);
    #1 check("R5", boost, 2'b00);
    run(2);

    // R6 + R9: inhibit mid-pulse, no resume
    tag = "R6"; dur = 16'd10;
    trig(2'b11);
    run(2);
    inh = 1'b1;
    #1 check("R6", boost, 2'b00);
    run(3);
    inh = 1'b0;
    tag = "R9";
    run(12);
    check("R9", boost, 2'b00);

    // R7: triggers during inhibit ignored
    tag = "R7"; inh = 1'b1;
    trig(2'b11);
    run(1);
    inh = 1'b0;
    run(12);
    check("R7", boost, 2'b00);

    // mixed traffic against the model
    tag = "R2"; dur = 16'd4;
    for (int i = 0; i < 40; i++) begin
      chg = 2'(i % 3 == 0 ? 1 : (i % 5 == 0 ? 2 : 0));
      inh = (i % 13 == 12);
      cyc();
    end
    chg = 2'b00; inh = 1'b0;
    run(8);

    // R1 again: asynchronous reset in mid-pulse
    tag = "R1"; dur = 16'd20;
    trig(2'b11);
    #2 rst_n = 1'b0;
    #1 check("R1", boost, 2'b00);
    @(negedge clk);
    run(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule